// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-to-physical page translations for a 14-bit virtual address space that maps onto a 12-bit physical space with 64-byte pages. It holds 16 translations arranged as 4 sets of 4 ways. A lookup is purely combinational. The virtual page number selects one set. The ways of that set are compared in parallel, and the hit, the physical page number and the assembled physical address come back in the same cycle.

Refills come from outside the block, for example from a page-table walker. The refill agent names the set and supplies a tag and page number. The block picks the way itself: it takes an empty way if one exists and otherwise the way under a per-set rotating pointer. A single-cycle flush discards every translation. Protection bits, page-table walking and fault handling belong to the surrounding logic.

Top module: `xlat_cache`

## Requirements
- R1: The low 6 address bits `va[5:0]` are the page offset. The page number is `va[13:6]`, the set is `va[7:6]` and the tag is `va[13:8]`. An entry placed in one set never answers a lookup that selects a different set, even when the tags are equal.
- R2: A lookup hits in the same cycle when a way of the selected set is valid and holds the lookup tag. `lk_ppn` then carries that way's 6-bit page number. On a miss, `lk_hit` and `lk_ppn` are both 0.
- R3: `lk_pa` is `{lk_ppn, va[5:0]}`. The offset bits never influence hit or page number.
- R4: With set 3 holding tag 0x03 mapped to page 0x0D, address 0x03D4 hits with page 0x0D and physical address 0x354.
- R5: When more than one way of the selected set matches, the lowest-numbered way supplies the page number and `lk_multi` is 1. Otherwise `lk_multi` is 0.
- R6: A fill with no flush writes the given tag and page into the lowest-numbered invalid way of `fill_set`. The entry is visible to lookups from the next cycle, not in the fill cycle.
- R7: A fill to a set whose 4 ways are all valid replaces the way under that set's rotating pointer. The pointer then advances by one, wrapping from 3 to 0. Fills that land in an invalid way leave the pointer unchanged.
- R8: `flush` clears all valid bits at the next edge. Lookups during the flush cycle miss, and a fill in the same cycle is dropped.
- R9: After reset every entry is invalid and every rotating pointer is at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 14 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a valid matching way |
| lk_multi | output | 1 | More than one way matched |
| lk_ppn | output | 6 | Physical page number of the hit, 0 on miss |
| lk_pa | output | 12 | Physical page number joined to the page offset |
| fill_en | input | 1 | Write a translation this cycle |
| fill_set | input | 2 | Set that receives the fill |
| fill_tag | input | 6 | Tag stored by the fill |
| fill_ppn | input | 6 | Page number stored by the fill |
| flush | input | 1 | Invalidate all entries |

## Verification
The embedded assertions check on every cycle the following:
- A multi-match is always also a hit.
- A flush leaves no hit in the following cycle.
- Every accepted fill sets the valid bit of the way it targeted.
- Each set's rotating pointer moves only on a replacement into a full set.

Only the bench's scenarios can show the rest:
- Which way is chosen and which older translation disappears after an eviction.
- That the lowest way wins a duplicate match.
- The fill-to-visibility latency.
- That the offset and set fields are split correctly against a known address.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  lk_hit,
  output logic                  lk_multi,
  output logic [PA_W-OFF_W-1:0] lk_ppn,
  output logic [PA_W-1:0]       lk_pa,
  input  logic                  fill_en,
  input  logic [$clog2(SETS)-1:0] fill_set,
  input  logic [VA_W-OFF_W-$clog2(SETS)-1:0] fill_tag,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  flush
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic             vld   [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  wire [IDX_W-1:0] lk_set = lk_va[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_va[OFF_W+IDX_W +: TAG_W];

  logic [WAYS-1:0]  match;
  logic [PPN_W-1:0] sel_ppn;

  always_comb begin
    sel_ppn = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      match[w] = vld[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      if (match[w]) sel_ppn = ppn_q[lk_set][w];
    end
  end

  assign lk_hit   = (|match) && !flush;
  assign lk_multi = ($countones(match) > 1) && !flush;
  assign lk_ppn   = lk_hit ? sel_ppn : '0;
  assign lk_pa    = {lk_ppn, lk_va[OFF_W-1:0]};

  logic [WAY_W-1:0] victim;
  logic             set_full;

  always_comb begin
    set_full = 1'b1;
    victim   = rr_q[fill_set];
    for (int w = 0; w < WAYS; w++) begin
      if (set_full && !vld[fill_set][w]) begin
        victim   = WAY_W'(w);
        set_full = 1'b0;
      end
    end
  end

  wire do_fill = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
    end else if (do_fill) begin
      vld[fill_set][victim] <= 1'b1;
      if (set_full) rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[fill_set][victim] <= fill_tag;
      ppn_q[fill_set][victim] <= fill_ppn;
    end
  end

  a_r5_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  for (genvar s = 0; s < SETS; s++) begin : g_chk_set
    a_r7_rr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_fill && set_full && fill_set == s) |=> $stable(rr_q[s]));
    for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
      a_r6_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (do_fill && fill_set == s && victim == w) |=> vld[s][w]);
    end
  end
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] lk_va = '0;
  logic        lk_hit, lk_multi;
  logic [5:0]  lk_ppn;
  logic [11:0] lk_pa;
  logic        fill_en = 0;
  logic [1:0]  fill_set = '0;
  logic [5:0]  fill_tag = '0;
  logic [5:0]  fill_ppn = '0;
  logic        flush = 0;

  always #4 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_multi(lk_multi), .lk_ppn(lk_ppn), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_ppn(fill_ppn), .flush(flush));

  int checks = 0;
  int fails  = 0;
  bit       m_vld [4][4];
  bit [5:0] m_tag [4][4];
  bit [5:0] m_ppn [4][4];
  int       m_rr  [4];

  function automatic void model_look(input logic [13:0] va, input bit fl,
                                     output bit h, output bit m, output logic [5:0] p);
    int n = 0;
    int s = va[7:6];
    h = 0; m = 0; p = '0;
    for (int w = 3; w >= 0; w--)
      if (m_vld[s][w] && m_tag[s][w] == va[13:8]) begin
        n++; p = m_ppn[s][w];
      end
    if (fl || n == 0) begin p = '0; n = 0; end
    h = (n > 0);
    m = (n > 1);
  endfunction

  function automatic void model_update(input bit fe, input logic [1:0] fs,
                                       input logic [5:0] ft, input logic [5:0] fp, input bit fl);
    int v = -1;
    if (fl) begin
      for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end else if (fe) begin
      for (int w = 0; w < 4; w++) if (v < 0 && !m_vld[fs][w]) v = w;
      if (v < 0) begin v = m_rr[fs]; m_rr[fs] = (m_rr[fs] + 1) % 4; end
      m_vld[fs][v] = 1; m_tag[fs][v] = ft; m_ppn[fs][v] = fp;
    end
  endfunction

  task automatic step(input logic [13:0] va, input bit fe, input logic [1:0] fs,
                      input logic [5:0] ft, input logic [5:0] fp, input bit fl, input string req);
    bit h, m; logic [5:0] p; logic [11:0] pa;
    @(negedge clk);
    lk_va = va; fill_en = fe; fill_set = fs; fill_tag = ft; fill_ppn = fp; flush = fl;
    #1;
    model_look(va, fl, h, m, p);
    pa = {p, va[5:0]};
    checks++;
    if (lk_hit !== h || lk_multi !== m || lk_ppn !== p || lk_pa !== pa) begin
      fails++;
      $display("FAIL %s va=%h actual hit=%b multi=%b ppn=%h pa=%h expected hit=%b multi=%b ppn=%h pa=%h",
               req, va, lk_hit, lk_multi, lk_ppn, lk_pa, h, m, p, pa);
    end
    @(posedge clk);
    model_update(fe, fs, ft, fp, fl);
  endtask

  function automatic logic [13:0] mkva(input logic [5:0] t, input logic [1:0] s, input logic [5:0] o);
    return {t, s, o};
  endfunction

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'h5eed1234;
    void'($urandom(seed));
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9: empty after reset
    step(14'h03D4, 0, 0, 0, 0, 0, "R9");
    step(14'h0000, 0, 0, 0, 0, 0, "R9");
    // R6: fill not visible in its own cycle
    step(14'h03D4, 1, 2'd3, 6'h03, 6'h0D, 0, "R6");
    // R4: worked example
    step(14'h03D4, 0, 0, 0, 0, 0, "R4");
    // R3: other offset, same page
    step(14'h03C0, 0, 0, 0, 0, 0, "R3");
    step(14'h03FF, 0, 0, 0, 0, 0, "R3");
    // R1: same tag, other set misses
    step(14'h0394, 0, 0, 0, 0, 0, "R1");
    // R7: fill set 0 past capacity; pointer starts at way 0 (R9)
    for (int i = 0; i < 5; i++) step(14'h0000, 1, 2'd0, 6'(10 + i), 6'(20 + i), 0, "R6");
    step(mkva(6'd10, 2'd0, 6'h05), 0, 0, 0, 0, 0, "R7");
    step(mkva(6'd11, 2'd0, 6'h05), 0, 0, 0, 0, 0, "R7");
    step(14'h0000, 1, 2'd0, 6'd15, 6'd30, 0, "R7");
    step(mkva(6'd11, 2'd0, 6'h01), 0, 0, 0, 0, 0, "R7");
    step(mkva(6'd12, 2'd0, 6'h01), 0, 0, 0, 0, 0, "R7");
    step(mkva(6'd15, 2'd0, 6'h01), 0, 0, 0, 0, 0, "R7");
    // R5: duplicate tag, lowest way wins
    step(14'h0000, 1, 2'd1, 6'h20, 6'h05, 0, "R6");
    step(14'h0000, 1, 2'd1, 6'h20, 6'h06, 0, "R6");
    step(mkva(6'h20, 2'd1, 6'h3A), 0, 0, 0, 0, 0, "R5");
    // R8: flush cycle misses, concurrent fill dropped
    step(14'h03D4, 1, 2'd2, 6'h01, 6'h11, 1, "R8");
    step(14'h03D4, 0, 0, 0, 0, 0, "R8");
    step(mkva(6'h01, 2'd2, 6'h00), 0, 0, 0, 0, 0, "R8");
    step(mkva(6'h20, 2'd1, 6'h00), 0, 0, 0, 0, 0, "R8");
    // random mix: R2 hits and misses, R5 duplicates, R7 eviction, R8 flushes
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] t = 6'($urandom_range(0, 7));
      step(mkva(t, 2'($urandom), 6'($urandom)),
           ($urandom_range(0, 2) == 0), 2'($urandom), 6'($urandom_range(0, 7)),
           6'($urandom), ($urandom_range(0, 60) == 0), "R2");
    end
    finish_run();
  end
endmodule